// File: doc/BRIEF.md
# UART Register File and Interrupt Controller

This block is the processor-facing side of a 16450-style serial port. A 32-bit word-addressed bus reaches eight registers: the data port, the interrupt enable, the interrupt identification, line control, modem control, line status, modem status and the baud divisor. Bit timing, framing and baud generation sit in a separate serialiser. This block only stores the line-control, modem-control and divisor words and drives them out on plain pins.

Received bytes come in as a stream beat (`rx_valid` with `rx_data`) and wait in a single holding register. Bytes to send leave as a one-cycle beat on `tx_valid` and `tx_data`. On the receive side, `rx_ready` is high only while the holding register is empty. A sender that respects it never loses data. A beat offered while `rx_ready` is low is still taken: it overwrites the held byte and sets the sticky overrun flag. The transmit beat has no back-pressure, so the serialiser must accept every beat.

A single level interrupt is chosen by fixed priority from the line status, the modem status and the enable bits. Read data is registered: it appears on `bus_rdata` one cycle after the read strobe. A one-cycle `bus_err` pulse marks every illegal access.

Top module: `uart_csr_core`

## Requirements
- R1: After reset, line status reads 0x60 (bit 5 holding empty, bit 6 transmitter empty, both always set), identification reads 0x01, `irq` is low, `rx_ready` is high and `line_ctl`, `modem_ctl`, `divisor` and `tx_valid` are zero.
- R2: A write to word offset 0 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to write-data bits 7:0.
- R3: A receive beat sets line status bit 0 (data ready). A read of offset 0 returns the held byte in bits 7:0 with the upper bits zero, and clears data ready.
- R4: A receive beat taken while data ready is set, with no data-port read in the same cycle, sets line status bit 1 (overrun). The new byte replaces the old one. Overrun stays set until reset. A data-port read and a beat in the same cycle return the old byte, keep the new one with data ready set, and raise no overrun.
- R5: Offsets 1 (enable, bits 3:0), 3 (line control), 4 (modem control, bits 1:0) and 7 (divisor) store written values. The stored values appear on `line_ctl`, `modem_ctl` and `divisor`, and a read of any of these four offsets returns zero.
- R6: Writes to offsets 2 (identification), 5 (line status) and 6 (modem status) change nothing.
- R7: Identification bit 0 is 1 and `irq` is low when no interrupt is pending. Otherwise bit 0 is 0, `irq` is high, and bits 2:1 name the pending source, highest priority first: 11 for any of line status bits 4:1 with enable bit 2; 10 for data ready with enable bit 0; 01 for holding empty with enable bit 1; 00 for any of modem status bits 3:0 with enable bit 3.
- R8: `modem_in` is registered each cycle into modem status, which reads back at offset 6.
- R9: Any of the following is illegal: an address with non-zero bits 1:0, an offset above 7, a read of a write-only offset, or a write to a read-only offset. An illegal access pulses `bus_err` for one cycle, reads zero and has no side effect.
- R10: `rx_ready` is high exactly while data ready is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after the read strobe |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| rx_valid | input | 1 | Receive beat valid |
| rx_data | input | BYTE_W | Receive byte |
| rx_ready | output | 1 | Holding register empty |
| tx_valid | output | 1 | Transmit beat, one cycle per data-port write |
| tx_data | output | BYTE_W | Transmit byte |
| modem_in | input | 8 | Modem status inputs |
| irq | output | 1 | Level interrupt |
| line_ctl | output | 8 | Stored line-control word |
| modem_ctl | output | 2 | Stored modem-control bits |
| divisor | output | DATA_W | Stored divisor |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume the inputs are stable across each rising edge. The bench drives every strobe for exactly one cycle. It changes inputs only on falling edges, and it never raises both bus strobes together. Receive beats are sent both with and without regard to `rx_ready`, so the overrun path is exercised on purpose. One beat is made to coincide with a data-port read to cover the same-cycle case.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int NUM_REGS = 8;
  localparam int OFF_W    = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_DATA  = 3'd0,
    OFF_IEN   = 3'd1,
    OFF_IID   = 3'd2,
    OFF_LCTL  = 3'd3,
    OFF_MCTL  = 3'd4,
    OFF_LSTAT = 3'd5,
    OFF_MSTAT = 3'd6,
    OFF_DIV   = 3'd7
  } reg_off_e;

  // identification codes placed in bits 2:1
  localparam logic [1:0] ID_LINE  = 2'b11;
  localparam logic [1:0] ID_RXD   = 2'b10;
  localparam logic [1:0] ID_THR   = 2'b01;
  localparam logic [1:0] ID_MODEM = 2'b00;

  // enable bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_THR   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int IEN_W    = 4;
endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output reg_off_e          off,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              bad
);
  logic in_range;
  logic wr_only;
  logic rd_only;

  generate
    if (ADDR_W > OFF_W + 2) begin : g_upper
      assign in_range = (addr[ADDR_W-1:OFF_W+2] == '0) && (addr[1:0] == 2'b00);
    end else begin : g_exact
      assign in_range = (addr[1:0] == 2'b00);
    end
  endgenerate

  assign off     = reg_off_e'(addr[OFF_W+1:2]);
  assign wr_only = (off == OFF_IEN) || (off == OFF_LCTL) ||
                   (off == OFF_MCTL) || (off == OFF_DIV);
  assign rd_only = (off == OFF_IID) || (off == OFF_LSTAT) || (off == OFF_MSTAT);

  assign rd_ok = rd && in_range && !wr_only;
  assign wr_ok = wr && in_range && !rd_only;
  assign bad   = (rd && !rd_ok) || (wr && !wr_ok);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              take,
  output logic [BYTE_W-1:0] held,
  output logic              ready_flag,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      ready_flag <= 1'b0;
      overrun    <= 1'b0;
    end else if (in_valid) begin
      held       <= in_data;
      ready_flag <= 1'b1;
      if (ready_flag && !take) overrun <= 1'b1;
    end else if (take) begin
      ready_flag <= 1'b0;
    end
  end

  p_beat_sets_ready_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ready_flag);

  p_overrun_set_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ready_flag && !take) |=> overrun);

  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_take_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (take && !in_valid) |=> !ready_flag);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       lstat,
  input  logic [3:0]       mstat_lo,
  input  logic [IEN_W-1:0] ien,
  output logic             irq,
  output logic [2:0]       iid
);
  logic line_p, rxd_p, thr_p, modem_p;

  assign line_p  = (|lstat[4:1]) && ien[EN_LINE];
  assign rxd_p   = lstat[0]      && ien[EN_RXD];
  assign thr_p   = lstat[5]      && ien[EN_THR];
  assign modem_p = (|mstat_lo)   && ien[EN_MODEM];

  assign irq = line_p | rxd_p | thr_p | modem_p;

  always_comb begin
    if (line_p)       iid = {ID_LINE, 1'b0};
    else if (rxd_p)   iid = {ID_RXD, 1'b0};
    else if (thr_p)   iid = {ID_THR, 1'b0};
    else if (modem_p) iid = {ID_MODEM, 1'b0};
    else              iid = 3'b001;
  end

  p_irq_vs_id_r7: assert property (@(posedge clk) disable iff (rst)
    irq == !iid[0]);

  p_line_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ((|lstat[4:1]) && ien[EN_LINE]) |-> (iid == 3'b110));
endmodule

// File: rtl/uart_csr_core.sv
module uart_csr_core
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic [7:0]        modem_in,
  output logic              irq,
  output logic [7:0]        line_ctl,
  output logic [1:0]        modem_ctl,
  output logic [DATA_W-1:0] divisor
);
  localparam int STAT_W = 8;
  localparam int PAD_W  = DATA_W - STAT_W;
  localparam int BPAD_W = DATA_W - BYTE_W;

  reg_off_e          off;
  logic              rd_ok, wr_ok, bad;
  logic [BYTE_W-1:0] held;
  logic              dr, oe;
  logic [IEN_W-1:0]  ien;
  logic [7:0]        mstat;
  logic [STAT_W-1:0] lstat;
  logic [2:0]        iid;
  logic [DATA_W-1:0] rd_mux;
  logic              take;

  uart_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .off(off), .rd_ok(rd_ok), .wr_ok(wr_ok), .bad(bad)
  );

  assign take = rd_ok && (off == OFF_DATA);

  uart_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .take(take), .held(held), .ready_flag(dr), .overrun(oe)
  );

  // bits: 6 temt, 5 thre (no transmitter here, so always empty), 4:2 unused errors
  assign lstat    = {1'b0, 1'b1, 1'b1, 3'b000, oe, dr};
  assign rx_ready = !dr;

  uart_irq_prio u_irq (
    .clk(clk), .rst(rst), .lstat(lstat[5:0]), .mstat_lo(mstat[3:0]),
    .ien(ien), .irq(irq), .iid(iid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      line_ctl  <= '0;
      modem_ctl <= '0;
      divisor   <= '0;
      mstat     <= '0;
    end else begin
      mstat <= modem_in;
      if (wr_ok) begin
        unique case (off)
          OFF_IEN:  ien       <= bus_wdata[IEN_W-1:0];
          OFF_LCTL: line_ctl  <= bus_wdata[7:0];
          OFF_MCTL: modem_ctl <= bus_wdata[1:0];
          OFF_DIV:  divisor   <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      unique case (off)
        OFF_DATA:  rd_mux = {{BPAD_W{1'b0}}, held};
        OFF_IID:   rd_mux = {{(DATA_W-3){1'b0}}, iid};
        OFF_LSTAT: rd_mux = {{PAD_W{1'b0}}, lstat};
        OFF_MSTAT: rd_mux = {{PAD_W{1'b0}}, mstat};
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      bus_err  <= bad;
      tx_valid <= wr_ok && (off == OFF_DATA);
      if (wr_ok && (off == OFF_DATA)) tx_data <= bus_wdata[BYTE_W-1:0];
    end
  end

  p_tx_beat_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0) |=> tx_valid);

  p_tx_cause_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_wr));

  p_err_out_of_range_r9: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && (bus_addr >= ADDR_W'(4 * NUM_REGS))) |=> (bus_err && (!$past(bus_rd) || bus_rdata == '0)));

  p_ready_tracks_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !take) |=> !rx_ready);

  p_fixed_lstat_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(4 * OFF_LSTAT)) |=> (bus_rdata[6:5] == 2'b11));
endmodule

// File: tb/uart_csr_core_tb_top.sv
module uart_csr_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data, line_ctl;
  logic [7:0]  modem_in = '0;
  logic [1:0]  modem_ctl;
  logic [31:0] divisor;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        took = 1'b0;

  always #2.5 clk = ~clk;

  uart_csr_core dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .modem_in(modem_in), .irq(irq),
    .line_ctl(line_ctl), .modem_ctl(modem_ctl), .divisor(divisor)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares registered read data the cycle after each read
  always @(posedge clk) took <= bus_rd;
  always @(negedge clk) begin
    if (took && !rst) begin
      if (exp_q.size() == 0) chk(0, "scoreboard underflow", bus_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 irq low", irq, 0);
    chk(rx_ready == 1, "R1 rx_ready", rx_ready, 1);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk({line_ctl, 6'b0, modem_ctl} == 0 && divisor == 0, "R1 cfg outputs", divisor, 0);
    bus_read(8'h14, 32'h60, "R1 line status");
    bus_read(8'h08, 32'h01, "R1 identification");

    // R2 transmit beat
    bus_write(8'h00, 32'h1234_56A5);
    chk(tx_valid == 1, "R2 tx_valid pulse", tx_valid, 1);
    chk(tx_data == 8'hA5, "R2 tx_data", tx_data, 8'hA5);
    @(negedge clk);
    chk(tx_valid == 0, "R2 tx_valid one cycle", tx_valid, 0);

    // R7 holding-empty source
    bus_write(8'h04, 32'h2);
    chk(irq == 1, "R7 irq thre", irq, 1);
    bus_read(8'h08, 32'h2, "R7 id thre");
    bus_write(8'h04, 32'h0);
    chk(irq == 0, "R7 irq off", irq, 0);

    // R3/R10 receive and read
    rx_send(8'h3C);
    chk(rx_ready == 0, "R10 not ready when full", rx_ready, 0);
    bus_read(8'h14, 32'h61, "R3 data ready set");
    bus_write(8'h04, 32'h1);
    bus_read(8'h08, 32'h4, "R7 id rx data");
    bus_read(8'h00, 32'h3C, "R3 read byte");
    chk(rx_ready == 1, "R10 ready after read", rx_ready, 1);
    bus_read(8'h14, 32'h60, "R3 data ready cleared");
    bus_read(8'h08, 32'h1, "R7 none pending");

    // R4 same-cycle read and beat
    rx_send(8'h77);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h00; rx_valid = 1'b1; rx_data = 8'h88;
    exp_q.push_back(32'h77); tag_q.push_back("R4 same-cycle old byte");
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    bus_read(8'h14, 32'h61, "R4 same-cycle no overrun");
    bus_read(8'h00, 32'h88, "R4 same-cycle new byte");

    // R4 overrun
    rx_send(8'h11);
    rx_send(8'h22);
    bus_read(8'h14, 32'h63, "R4 overrun set");
    bus_read(8'h00, 32'h22, "R4 byte replaced");
    bus_read(8'h14, 32'h62, "R4 overrun sticky");
    bus_write(8'h04, 32'h5);
    bus_read(8'h08, 32'h6, "R7 id line error");
    bus_write(8'h04, 32'h7);
    bus_read(8'h08, 32'h6, "R7 line beats thre");
    bus_write(8'h04, 32'h3);
    bus_read(8'h08, 32'h2, "R7 thre when no data");
    rx_send(8'h55);
    bus_read(8'h08, 32'h4, "R7 data beats thre");
    bus_read(8'h00, 32'h55, "R3 read 0x55");

    // R8 modem status
    @(negedge clk); modem_in = 8'h05;
    bus_read(8'h18, 32'h05, "R8 modem readback");
    bus_write(8'h04, 32'h8);
    chk(irq == 1, "R7 irq modem", irq, 1);
    bus_read(8'h08, 32'h0, "R7 id modem");
    @(negedge clk); modem_in = 8'hF0;
    bus_read(8'h18, 32'hF0, "R8 modem upper");
    bus_read(8'h08, 32'h1, "R7 modem upper bits ignored");
    chk(irq == 0, "R7 irq low upper bits", irq, 0);

    // R5 write-only config
    bus_write(8'h0C, 32'hAB);
    chk(line_ctl == 8'hAB, "R5 line_ctl", line_ctl, 8'hAB);
    bus_write(8'h1C, 32'h0001_2345);
    chk(divisor == 32'h0001_2345, "R5 divisor", divisor, 32'h0001_2345);
    bus_write(8'h10, 32'h3);
    chk(modem_ctl == 2'b11, "R5 modem_ctl", modem_ctl, 3);
    bus_read(8'h0C, 32'h0, "R5 line ctl reads zero");
    chk(bus_err == 1, "R9 err on write-only read", bus_err, 1);
    bus_read(8'h04, 32'h0, "R5 enable reads zero");
    bus_read(8'h1C, 32'h0, "R5 divisor reads zero");

    // R6 read-only ignore writes
    bus_write(8'h14, 32'hFF);
    chk(bus_err == 1, "R9 err on read-only write", bus_err, 1);
    bus_read(8'h14, 32'h62, "R6 line status unchanged");
    bus_write(8'h08, 32'h0);
    bus_read(8'h08, 32'h1, "R6 identification unchanged");
    bus_write(8'h18, 32'h0F);
    bus_read(8'h18, 32'hF0, "R6 modem status unchanged");

    // R9 out of range and misaligned
    bus_read(8'h20, 32'h0, "R9 out of range read zero");
    chk(bus_err == 1, "R9 err out of range", bus_err, 1);
    @(negedge clk);
    chk(bus_err == 0, "R9 err one cycle", bus_err, 0);
    bus_write(8'h24, 32'h99);
    chk(bus_err == 1 && tx_valid == 0, "R9 bad write no effect", {tx_valid, bus_err}, 32'h1);
    bus_write(8'h01, 32'h99);
    chk(bus_err == 1 && tx_valid == 0, "R9 misaligned write no tx", {tx_valid, bus_err}, 32'h1);
    bus_read(8'h0C, 32'h0, "R9 readback path still zero");
    chk(line_ctl == 8'hAB, "R9 line_ctl untouched", line_ctl, 8'hAB);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule